// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

A 16-bit timer channel that counts down from a programmable value and, each time it passes zero, reloads itself and raises an interrupt request. The count source is one of four prescaled system-clock taps in timer mode. In event mode it is either edges on an asynchronous external pin or overflow pulses from a neighbouring channel.

A host reaches the channel through a byte-wide register port with four addresses: count low byte, count high byte, mode, and control. A value written while the channel is stopped presets both the reload register and the live counter. A value written while the channel runs changes only the reload register, and the counter takes it up at its next reload. The live count can be read at any time, and a read does not disturb counting. The interrupt request appears in two forms: a one-cycle pulse for a neighbour or an interrupt controller, and a sticky flag that the host clears.

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter, the reload register, the mode register, the start bit and the interrupt flag are all zero, and every read address returns 0x00.
- R2: While the start bit is 0, a write to address 0 (low byte) or address 1 (high byte) stores that byte in both the reload register and the counter.
- R3: While the start bit (control address 3, bit 0) is 0, the counter holds its value whatever the count source does.
- R4: With mode bits 1:0 = 00 (timer), mode bits 7:6 select the tick period: 00 = 2, 01 = 16, 10 = 64, 11 = 512 system clocks. A reload value R therefore gives an overflow interval of (R+1)·period clocks.
- R5: On a tick with the counter at 0x0000, the counter loads the reload value and `irq_pulse` is high for exactly the following cycle. On any other running tick the counter decrements by one.
- R6: `irq_flag` (control bit 1) is set on every overflow and stays set. A control write with bit 1 = 0 clears it, and a write with bit 1 = 1 leaves it alone. An overflow in the same cycle as a clearing write leaves the flag set.
- R7: While running, a count write changes only the reload register, and the counter keeps counting undisturbed. If the write falls in the same cycle as a reload, the counter loads the newly written byte.
- R8: `rd_data` shows, one cycle after `rd_addr` is applied: address 0 = count low byte, 1 = count high byte, 2 = mode, 3 = {6'b0, flag, start}. Reads never change the count.
- R9: With mode bits 1:0 = 01 and mode bit 4 = 0, the channel counts edges of `ext_in` after a two-flop synchroniser. Mode bits 3:2 choose the edge: 00 = rising, 01 = falling, 1x = both.
- R10: With mode bits 1:0 = 01 and mode bit 4 = 1, each high cycle of `casc_in` is one tick, and `ext_in` is ignored.
- R11: Mode bits 1:0 = 10 or 11 produce no ticks, so the counter holds even with the start bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count lo, 1 count hi, 2 mode, 3 control) |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Registered read data, one cycle after rd_addr |
| ext_in | input | 1 | Asynchronous external event input |
| casc_in | input | 1 | Overflow pulse from a neighbouring channel |
| irq_pulse | output | 1 | One-cycle overflow pulse |
| irq_flag | output | 1 | Sticky interrupt request bit |

## Verification
Two collisions matter here, and both involve a reload at zero. A host count write can land in the same cycle as the reload, and a clearing control write can land in the same cycle as the overflow that sets the flag. The bench uses the cascade input as a count source because it controls exactly which cycle ticks: it drives the last `casc_in` pulse in the same cycle as the write. It then judges the result by reading back the count, which must equal the freshly written byte, and by checking that the flag is still set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_TIMER = 2'b00,
    MD_EVENT = 2'b01,
    MD_IDLE2 = 2'b10,
    MD_IDLE3 = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] A_CNT_LO = 2'd0;
  localparam logic [1:0] A_CNT_HI = 2'd1;
  localparam logic [1:0] A_MODE   = 2'd2;
  localparam logic [1:0] A_CTRL   = 2'd3;

  localparam int MB_CASC  = 4;
  localparam int MB_EDGE  = 2;
  localparam int MB_TAP   = 6;
  localparam int CB_START = 0;
  localparam int CB_FLAG  = 1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int E0 = 1,
  parameter int E1 = 4,
  parameter int E2 = 6,
  parameter int E3 = 9
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] taps
);
  localparam int PW = E3;

  function automatic int exp_of(input int i);
    case (i)
      0: exp_of = E0;
      1: exp_of = E1;
      2: exp_of = E2;
      default: exp_of = E3;
    endcase
  endfunction

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_tap
    localparam int E = exp_of(i);
    assign taps[i] = &pre_q[E-1:0];
  end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] pol,
  output logic       pulse
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic                   last_q;
  logic                   cur;

  assign cur = sh_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SYNC_STAGES-2:0], pin};
      last_q <= cur;
    end
  end

  always_comb begin
    case (pol)
      2'b00:   pulse = cur & ~last_q;
      2'b01:   pulse = ~cur & last_q;
      default: pulse = cur ^ last_q;
    endcase
  end
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int BW = 8,
  parameter int W  = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  reload,
  output logic          hit,
  output logic          irq_q
);
  logic [W-1:0] reload_nx;

  always_comb begin
    reload_nx = reload;
    if (wr_lo) reload_nx[BW-1:0] = wdata;
    if (wr_hi) reload_nx[W-1:BW] = wdata;
  end

  assign hit = run && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      reload <= '0;
      irq_q  <= 1'b0;
    end else begin
      reload <= reload_nx;
      irq_q  <= hit;
      if (!run) begin
        if (wr_lo) cnt[BW-1:0] <= wdata;
        if (wr_hi) cnt[W-1:BW] <= wdata;
      end else if (tick) begin
        if (cnt == '0) cnt <= reload_nx;
        else           cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TAP_E0      = 1,
  parameter int TAP_E1      = 4,
  parameter int TAP_E2      = 6,
  parameter int TAP_E3      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              ext_in,
  input  logic              casc_in,
  output logic              irq_pulse,
  output logic              irq_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] mode_q;
  logic              start_q;
  logic              flag_q;
  logic [BYTE_W-1:0] rd_q;
  logic [3:0]        taps;
  logic              edge_pulse;
  logic              cnt_tick;
  logic              hit;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  reload_q;
  logic              wr_lo, wr_hi, wr_mode, wr_ctrl;
  tmr_mode_e         md;

  assign wr_lo   = wr_en && (wr_addr == A_CNT_LO);
  assign wr_hi   = wr_en && (wr_addr == A_CNT_HI);
  assign wr_mode = wr_en && (wr_addr == A_MODE);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign md      = tmr_mode_e'(mode_q[1:0]);

  tmr_prescale #(.E0(TAP_E0), .E1(TAP_E1), .E2(TAP_E2), .E3(TAP_E3)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .taps (taps)
  );

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .pin   (ext_in),
    .pol   (mode_q[MB_EDGE+1:MB_EDGE]),
    .pulse (edge_pulse)
  );

  always_comb begin
    case (md)
      MD_TIMER: cnt_tick = taps[mode_q[MB_TAP+1:MB_TAP]];
      MD_EVENT: cnt_tick = mode_q[MB_CASC] ? casc_in : edge_pulse;
      default:  cnt_tick = 1'b0;
    endcase
  end

  tmr_down #(.BW(BYTE_W), .W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (start_q),
    .tick   (cnt_tick),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wdata  (wr_data),
    .cnt    (cnt_q),
    .reload (reload_q),
    .hit    (hit),
    .irq_q  (irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      start_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wr_data;
      if (wr_ctrl) start_q <= wr_data[CB_START];
      if (hit)                               flag_q <= 1'b1;
      else if (wr_ctrl && !wr_data[CB_FLAG]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        A_CNT_LO: rd_q <= cnt_q[BYTE_W-1:0];
        A_CNT_HI: rd_q <= cnt_q[CNT_W-1:BYTE_W];
        A_MODE:   rd_q <= mode_q;
        default:  rd_q <= {{(BYTE_W-2){1'b0}}, flag_q, start_q};
      endcase
    end
  end

  assign rd_data  = rd_q;
  assign irq_flag = flag_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             tick,
  input logic             wr_cnt,
  input logic [1:0]       md,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             irq_pulse,
  input logic             irq_flag
);
  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt) |=> $stable(cnt));

  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt == '0 && !wr_cnt) |=> (cnt == $past(reload) && irq_pulse));

  p_no_spurious_irq_r5: assert property (@(posedge clk) disable iff (rst)
    !(run && tick && cnt == '0) |=> !irq_pulse);

  p_flag_follows_r6: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_flag);

  p_run_write_r7: assert property (@(posedge clk) disable iff (rst)
    (run && wr_cnt && !tick) |=> $stable(cnt));

  p_idle_mode_r11: assert property (@(posedge clk) disable iff (rst)
    (md[1] && !wr_cnt) |=> $stable(cnt));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (start_q),
  .tick      (cnt_tick),
  .wr_cnt    (wr_lo | wr_hi),
  .md        (mode_q[1:0]),
  .cnt       (cnt_q),
  .reload    (reload_q),
  .irq_pulse (irq_pulse),
  .irq_flag  (irq_flag)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       ext_in = 1'b0;
  logic       casc_in = 1'b0;
  logic       irq_pulse;
  logic       irq_flag;

  int n_run = 0;
  int n_fail = 0;
  int cyc_n = 0;

  always #2.5 clk = ~clk;

  tmr_chan uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in), .casc_in(casc_in),
    .irq_pulse(irq_pulse), .irq_flag(irq_flag)
  );

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d, input logic cs);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; casc_in = cs;
    @(negedge clk);
    wr_en = 1'b0; casc_in = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic casc(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, 1'b1);
  endtask

  task automatic preset(input logic [7:0] mode, input int val);
    wr(2'd3, 8'h00);
    wr(2'd2, mode);
    wr(2'd0, val[7:0]);
    wr(2'd1, val[15:8]);
  endtask

  task automatic meas(output int iv);
    int guard;
    guard = 0;
    @(negedge clk);
    while (!irq_pulse && guard < 5000) begin @(negedge clk); guard++; end
    iv = 0;
    do begin @(negedge clk); iv++; end while (!irq_pulse && iv < 5000);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1'b1; idle(4);
      ext_in = 1'b0; idle(4);
    end
  endtask

  initial begin
    int v;
    int iv;
    int periods [4] = '{2, 16, 64, 512};
    idle(3);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset flag", int'(irq_flag), 0);

    // R2: stopped write presets the counter; R8 read map
    preset(8'h00, 16'h1234);
    rd(2'd0, v); chk("R2 count lo", v, 8'h34);
    rd(2'd1, v); chk("R2 count hi", v, 8'h12);
    rd(2'd2, v); chk("R8 mode read", v, 0);

    // R3: frozen while stopped, even with a fast tap
    preset(8'h00, 77);
    idle(40);
    rd(2'd0, v); chk("R3 frozen", v, 77);
    wr(2'd3, 8'h01);
    idle(20);
    wr(2'd3, 8'h00);
    rd(2'd0, v); chk("R3 runs once started", int'(v < 77), 1);

    // R4/R5: overflow interval sweep over taps and reload values
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < 3; r += 2) begin
        preset(8'(t << 6), r);
        wr(2'd3, 8'h01);
        meas(iv);
        chk($sformatf("R4 tap %0d reload %0d interval", t, r), iv, (r + 1) * periods[t]);
      end
    end

    // R10/R5: cascade source, external pin ignored
    preset(8'h11, 2);
    wr(2'd3, 8'h01);
    ext_pulses(2);
    rd(2'd0, v); chk("R10 ext ignored", v, 2);
    casc(2);
    rd(2'd0, v); chk("R10 casc counted", v, 0);
    chk("R6 flag clear before", int'(irq_flag), 0);
    cyc(1'b0, 2'd0, 8'd0, 1'b1);
    chk("R5 irq pulse", int'(irq_pulse), 1);
    @(negedge clk);
    chk("R5 irq pulse one cycle", int'(irq_pulse), 0);
    rd(2'd0, v); chk("R5 reloaded", v, 2);
    chk("R6 flag set", int'(irq_flag), 1);

    // R6: sticky flag and clearing
    wr(2'd3, 8'h03);
    chk("R6 write 1 keeps flag", int'(irq_flag), 1);
    rd(2'd3, v); chk("R8 ctrl read", v, 3);
    wr(2'd3, 8'h01);
    chk("R6 write 0 clears", int'(irq_flag), 0);
    casc(2);
    cyc(1'b1, 2'd3, 8'h01, 1'b1);
    chk("R6 set wins over clear", int'(irq_flag), 1);

    // R7: running write goes only to reload; coincident write loads new value
    wr(2'd3, 8'h01);
    casc(1);
    wr(2'd0, 8'd9);
    rd(2'd0, v); chk("R7 counter untouched", v, 1);
    casc(1);
    rd(2'd1, v); chk("R8 hi read while running", v, 0);
    casc(1);
    rd(2'd0, v); chk("R7 next reload takes new", v, 9);
    casc(9);
    rd(2'd0, v); chk("R7 at zero", v, 0);
    cyc(1'b1, 2'd0, 8'd5, 1'b1);
    rd(2'd0, v); chk("R7 coincident write", v, 5);

    // R8: reads do not disturb counting
    for (int i = 0; i < 3; i++) begin
      rd(2'd0, v);
      casc(1);
    end
    rd(2'd0, v); chk("R8 reads harmless", v, 2);

    // R9: external edges with each polarity
    for (int p = 0; p < 3; p++) begin
      preset(8'(8'h01 | (p << 2)), 100);
      wr(2'd3, 8'h01);
      ext_pulses(3);
      idle(6);
      wr(2'd3, 8'h00);
      rd(2'd0, v);
      chk($sformatf("R9 polarity %0d", p), v, (p == 2) ? 94 : 97);
    end

    // R11: reserved modes do not count
    preset(8'h02, 50);
    wr(2'd3, 8'h01);
    idle(600);
    rd(2'd0, v); chk("R11 mode 10 holds", v, 50);
    preset(8'h13, 50);
    wr(2'd3, 8'h01);
    casc(3);
    rd(2'd0, v); chk("R11 mode 11 holds", v, 50);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule